// File: doc/BRIEF.md
# Shared Memory DMA Slot Arbiter

This block decides who owns a shared memory bus on each bus cycle. The bus can go to the processor or to one channel in seven DMA groups: block mover, display plane fetch, display list engine, sound, moving objects, floppy and DRAM refresh. Every requester holds its request line high while it wants the bus. The winner sees its grant line high for that same cycle and gives up the bus at the next cycle. Grants are combinational from the current requests and the block's registered state, so a requester can act on a grant in the cycle where it appears.

A horizontal position counter runs through the bus cycles of one raster line and wraps at the line length. Five groups are tied to the display and each has a fixed number of slots per line. When a group has used its slots, it stops winning until the next line. The processor is preferred on even positions and DMA on odd positions. The block mover outranks everything but can be throttled: while its priority flag is low, it hands every fourth cycle to a waiting processor. Channels inside one group take turns. With overscan enabled, display fetch may run past its own allowance, and each extra slot is taken from the moving-object allowance.

Top module: `dma_slot_arbiter`

## Requirements
- R1: In any cycle at most one grant is high across `cpu_gnt` and all channel grant lines. A grant line is high only while its own request line is high.
- R2: Among DMA groups the order of precedence is block mover, plane fetch, display list, sound, objects, floppy, refresh. A lower group wins only when no higher group is eligible.
- R3: On an even `hpos` a processor request wins over every group except the block mover. On an odd `hpos` every eligible group wins over the processor. The processor gets any cycle that no eligible group takes.
- R4: Channels within one group are served in rotation. After channel i is granted, that group's next grant goes to the first requesting channel at index i+1, i+2, … with wrap-around. Channel index k is bit k of the group's request vector.
- R5: `hpos` counts 0, 1, … up to LINE_CYCLES-1 and then returns to 0. All per-line allowances are refilled at that wrap. A grant in the last cycle of a line is charged to that line.
- R6: Per line, plane fetch receives at most 80 grants with overscan off. Objects receive at most 16, sound 4, floppy 3 and refresh 4. A group whose allowance is used up is skipped, and the cycle goes to the next eligible requester.
- R7: While `blt_pri` is low, after three block-mover grants in a row with the processor requesting, the next cycle goes to the processor if it is still requesting. The run count restarts when the processor is granted or stops requesting.
- R8: While `blt_pri` is high, a requesting block mover wins every cycle and never yields to the processor.
- R9: With `overscan_en` high, plane fetch may keep winning after its 80 grants. Each such extra grant uses one object slot, so plane fetch plus objects never exceed 96 grants per line.
- R10: Synchronous active-low reset returns `hpos` to 0, empties all allowance counters and the yield run count, and points each rotation at channel 0.
- R11: The block mover and display list groups have no per-line limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor wants the bus |
| blt_pri | input | 1 | Block mover keeps the bus without yielding |
| overscan_en | input | 1 | Extra plane fetch slots are taken from objects |
| blt_req | input | 4 | Block mover channel requests |
| bpl_req | input | 6 | Plane fetch channel requests |
| cop_req | input | 1 | Display list engine request |
| aud_req | input | 4 | Sound channel requests |
| spr_req | input | 8 | Moving object channel requests |
| dsk_req | input | 1 | Floppy request |
| ref_req | input | 1 | DRAM refresh request |
| cpu_gnt | output | 1 | Processor owns this cycle |
| blt_gnt | output | 4 | Block mover channel grants |
| bpl_gnt | output | 6 | Plane fetch channel grants |
| cop_gnt | output | 1 | Display list engine grant |
| aud_gnt | output | 4 | Sound channel grants |
| spr_gnt | output | 8 | Moving object channel grants |
| dsk_gnt | output | 1 | Floppy grant |
| ref_gnt | output | 1 | Refresh grant |
| hpos | output | 8 | Bus cycle position within the line |

## Verification
The assertions check these rules on every cycle:
- one-hot grants, each backed by its own request;
- an exhausted allowance never granting, including the shared plane and object pool under overscan;
- the processor winning free even slots and losing odd ones to the display list engine;
- the line counter stepping and wrapping;
- a throttled block mover never taking a fourth straight slot from a waiting processor.

Rotation order, exact per-line totals, the three-to-one share under throttling and the refill at each line boundary cannot be seen in one cycle. These come from the bench scenarios and its cycle-by-cycle reference model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int NUM_GRP = 7;
  // group index doubles as precedence: lower index wins
  localparam int G_BLT = 0;
  localparam int G_BPL = 1;
  localparam int G_COP = 2;
  localparam int G_AUD = 3;
  localparam int G_SPR = 4;
  localparam int G_DSK = 5;
  localparam int G_REF = 6;

  typedef struct packed {
    logic                cpu;
    logic [NUM_GRP-1:0]  grp;
  } arb_win_t;

  // Slot decision: block mover first, then the processor on even slots,
  // then the remaining groups by index, then the processor on leftovers.
  function automatic arb_win_t arb_pick(input logic [NUM_GRP-1:0] ok,
                                        input logic cpu_req,
                                        input logic even_slot);
    arb_win_t w;
    w = '0;
    if (ok[G_BLT]) begin
      w.grp[G_BLT] = 1'b1;
    end else if (even_slot && cpu_req) begin
      w.cpu = 1'b1;
    end else begin
      for (int g = 1; g < NUM_GRP; g++) begin
        if (ok[g] && (w.grp == '0)) w.grp[g] = 1'b1;
      end
      if ((w.grp == '0) && cpu_req) w.cpu = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win_idx;
  logic          hit;

  always_comb begin
    int idx;
    gnt     = '0;
    win_idx = '0;
    hit     = 1'b0;
    for (int off = 0; off < N; off++) begin
      idx = int'(ptr) + off;
      if (idx >= N) idx = idx - N;
      if (!hit && req[idx]) begin
        hit      = 1'b1;
        gnt[idx] = 1'b1;
        win_idx  = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (take && hit) begin
      ptr <= (win_idx == PW'(N-1)) ? '0 : win_idx + 1'b1;
    end
  end

endmodule

// File: rtl/dma_budget_ctr.sv
module dma_budget_ctr #(
  parameter int LIMIT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(LIMIT+1)-1:0]   used,
  output logic                         room
);
  localparam int W = $clog2(LIMIT+1);

  assign room = (used < W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      used <= '0;
    end else if (inc && room) begin
      used <= used + 1'b1;
    end
  end

endmodule

// File: rtl/dma_line_budget.sv
module dma_line_budget
  import dma_arb_pkg::*;
#(
  parameter int LINE_CYCLES = 227,
  parameter int BPL_BUDGET  = 80,
  parameter int SPR_BUDGET  = 16,
  parameter int AUD_BUDGET  = 4,
  parameter int DSK_BUDGET  = 3,
  parameter int REF_BUDGET  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              overscan_en,
  input  logic [NUM_GRP-1:0]                win,
  output logic [$clog2(LINE_CYCLES)-1:0]    hpos,
  output logic [NUM_GRP-1:0]                room,
  output logic [$clog2(BPL_BUDGET+1)-1:0]   bpl_used,
  output logic [$clog2(SPR_BUDGET+1)-1:0]   spr_used,
  output logic [$clog2(AUD_BUDGET+1)-1:0]   aud_used,
  output logic [$clog2(DSK_BUDGET+1)-1:0]   dsk_used,
  output logic [$clog2(REF_BUDGET+1)-1:0]   ref_used
);
  localparam int HW = $clog2(LINE_CYCLES);

  logic line_end;
  logic bpl_room, spr_room, aud_room, dsk_room, ref_room;
  logic spr_inc;

  assign line_end = (hpos == HW'(LINE_CYCLES-1));

  always_ff @(posedge clk) begin
    if (!rst_n)        hpos <= '0;
    else if (line_end) hpos <= '0;
    else               hpos <= hpos + 1'b1;
  end

  // plane fetch past its own allowance draws from the object pool
  assign spr_inc = win[G_SPR] | (win[G_BPL] & ~bpl_room);

  dma_budget_ctr #(.LIMIT(BPL_BUDGET)) u_bpl (
    .clk(clk), .rst_n(rst_n), .clr(line_end), .inc(win[G_BPL]),
    .used(bpl_used), .room(bpl_room));
  dma_budget_ctr #(.LIMIT(SPR_BUDGET)) u_spr (
    .clk(clk), .rst_n(rst_n), .clr(line_end), .inc(spr_inc),
    .used(spr_used), .room(spr_room));
  dma_budget_ctr #(.LIMIT(AUD_BUDGET)) u_aud (
    .clk(clk), .rst_n(rst_n), .clr(line_end), .inc(win[G_AUD]),
    .used(aud_used), .room(aud_room));
  dma_budget_ctr #(.LIMIT(DSK_BUDGET)) u_dsk (
    .clk(clk), .rst_n(rst_n), .clr(line_end), .inc(win[G_DSK]),
    .used(dsk_used), .room(dsk_room));
  dma_budget_ctr #(.LIMIT(REF_BUDGET)) u_ref (
    .clk(clk), .rst_n(rst_n), .clr(line_end), .inc(win[G_REF]),
    .used(ref_used), .room(ref_room));

  always_comb begin
    room        = '0;
    room[G_BLT] = 1'b1;
    room[G_BPL] = bpl_room | (overscan_en & spr_room);
    room[G_COP] = 1'b1;
    room[G_AUD] = aud_room;
    room[G_SPR] = spr_room;
    room[G_DSK] = dsk_room;
    room[G_REF] = ref_room;
  end

endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_BLT       = 4,
  parameter int N_BPL       = 6,
  parameter int N_COP       = 1,
  parameter int N_AUD       = 4,
  parameter int N_SPR       = 8,
  parameter int N_DSK       = 1,
  parameter int N_REF       = 1,
  parameter int LINE_CYCLES = 227,
  parameter int BPL_BUDGET  = 80,
  parameter int SPR_BUDGET  = 16,
  parameter int AUD_BUDGET  = 4,
  parameter int DSK_BUDGET  = 3,
  parameter int REF_BUDGET  = 4,
  parameter int YIELD_EVERY = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_req,
  input  logic                            blt_pri,
  input  logic                            overscan_en,
  input  logic [N_BLT-1:0]                blt_req,
  input  logic [N_BPL-1:0]                bpl_req,
  input  logic [N_COP-1:0]                cop_req,
  input  logic [N_AUD-1:0]                aud_req,
  input  logic [N_SPR-1:0]                spr_req,
  input  logic [N_DSK-1:0]                dsk_req,
  input  logic [N_REF-1:0]                ref_req,
  output logic                            cpu_gnt,
  output logic [N_BLT-1:0]                blt_gnt,
  output logic [N_BPL-1:0]                bpl_gnt,
  output logic [N_COP-1:0]                cop_gnt,
  output logic [N_AUD-1:0]                aud_gnt,
  output logic [N_SPR-1:0]                spr_gnt,
  output logic [N_DSK-1:0]                dsk_gnt,
  output logic [N_REF-1:0]                ref_gnt,
  output logic [$clog2(LINE_CYCLES)-1:0]  hpos
);
  localparam int GRP_N [NUM_GRP] = '{N_BLT, N_BPL, N_COP, N_AUD, N_SPR, N_DSK, N_REF};

  function automatic int grp_off(input int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += GRP_N[i];
    return s;
  endfunction

  localparam int TOTAL = grp_off(NUM_GRP);
  localparam int YW    = (YIELD_EVERY > 2) ? $clog2(YIELD_EVERY) : 1;

  // named internal events, also watched by the bound checker
  logic [TOTAL-1:0]    all_req;
  logic [TOTAL-1:0]    all_gnt;
  logic [NUM_GRP-1:0]  grp_req;
  logic [NUM_GRP-1:0]  grp_ok;
  logic [NUM_GRP-1:0]  room;
  logic                even_slot;
  logic                blt_hold;
  logic [YW-1:0]       yld_cnt;
  arb_win_t            win;
  logic [$clog2(BPL_BUDGET+1)-1:0] bpl_used;
  logic [$clog2(SPR_BUDGET+1)-1:0] spr_used;
  logic [$clog2(AUD_BUDGET+1)-1:0] aud_used;
  logic [$clog2(DSK_BUDGET+1)-1:0] dsk_used;
  logic [$clog2(REF_BUDGET+1)-1:0] ref_used;

  assign all_req = {ref_req, dsk_req, spr_req, aud_req, cop_req, bpl_req, blt_req};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int GN = GRP_N[g];
    localparam int GO = grp_off(g);
    logic [GN-1:0] sub_gnt;

    dma_rr_pick #(.N(GN)) u_rr (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (all_req[GO +: GN]),
      .take (win.grp[g]),
      .gnt  (sub_gnt)
    );

    assign all_gnt[GO +: GN] = sub_gnt & {GN{win.grp[g]}};
    assign grp_req[g]        = |all_req[GO +: GN];
  end

  dma_line_budget #(
    .LINE_CYCLES(LINE_CYCLES), .BPL_BUDGET(BPL_BUDGET), .SPR_BUDGET(SPR_BUDGET),
    .AUD_BUDGET(AUD_BUDGET), .DSK_BUDGET(DSK_BUDGET), .REF_BUDGET(REF_BUDGET)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .overscan_en(overscan_en), .win(win.grp),
    .hpos(hpos), .room(room),
    .bpl_used(bpl_used), .spr_used(spr_used), .aud_used(aud_used),
    .dsk_used(dsk_used), .ref_used(ref_used)
  );

  assign even_slot = ~hpos[0];
  assign blt_hold  = ~blt_pri & cpu_req & (yld_cnt == YW'(YIELD_EVERY-1));

  always_comb begin
    grp_ok        = grp_req & room;
    grp_ok[G_BLT] = grp_req[G_BLT] & ~blt_hold;
  end

  assign win     = arb_pick(grp_ok, cpu_req, even_slot);
  assign cpu_gnt = win.cpu;

  always_ff @(posedge clk) begin
    if (!rst_n || win.cpu || !cpu_req) begin
      yld_cnt <= '0;
    end else if (win.grp[G_BLT] && (yld_cnt != YW'(YIELD_EVERY-1))) begin
      yld_cnt <= yld_cnt + 1'b1;
    end
  end

  assign blt_gnt = all_gnt[grp_off(G_BLT) +: N_BLT];
  assign bpl_gnt = all_gnt[grp_off(G_BPL) +: N_BPL];
  assign cop_gnt = all_gnt[grp_off(G_COP) +: N_COP];
  assign aud_gnt = all_gnt[grp_off(G_AUD) +: N_AUD];
  assign spr_gnt = all_gnt[grp_off(G_SPR) +: N_SPR];
  assign dsk_gnt = all_gnt[grp_off(G_DSK) +: N_DSK];
  assign ref_gnt = all_gnt[grp_off(G_REF) +: N_REF];

endmodule

// File: rtl/dma_slot_arbiter_chk.sv
module dma_slot_arbiter_chk #(
  parameter int N_BLT       = 4,
  parameter int N_BPL       = 6,
  parameter int N_COP       = 1,
  parameter int N_AUD       = 4,
  parameter int N_SPR       = 8,
  parameter int N_DSK       = 1,
  parameter int N_REF       = 1,
  parameter int LINE_CYCLES = 227,
  parameter int BPL_BUDGET  = 80,
  parameter int SPR_BUDGET  = 16,
  parameter int AUD_BUDGET  = 4,
  parameter int DSK_BUDGET  = 3,
  parameter int REF_BUDGET  = 4,
  parameter int YIELD_EVERY = 4,
  localparam int TOT = N_BLT + N_BPL + N_COP + N_AUD + N_SPR + N_DSK + N_REF,
  localparam int HW  = $clog2(LINE_CYCLES)
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cpu_req,
  input logic                               blt_pri,
  input logic                               overscan_en,
  input logic [TOT-1:0]                     req_all,
  input logic [TOT-1:0]                     gnt_all,
  input logic                               cpu_gnt,
  input logic [HW-1:0]                      hpos,
  input logic [$clog2(BPL_BUDGET+1)-1:0]    bpl_used,
  input logic [$clog2(SPR_BUDGET+1)-1:0]    spr_used,
  input logic [$clog2(AUD_BUDGET+1)-1:0]    aud_used,
  input logic [$clog2(DSK_BUDGET+1)-1:0]    dsk_used,
  input logic [$clog2(REF_BUDGET+1)-1:0]    ref_used
);
  localparam int O_BPL = N_BLT;
  localparam int O_COP = O_BPL + N_BPL;
  localparam int O_AUD = O_COP + N_COP;
  localparam int O_SPR = O_AUD + N_AUD;
  localparam int O_DSK = O_SPR + N_SPR;
  localparam int O_REF = O_DSK + N_DSK;

  logic any_blt_g, any_bpl_g, any_aud_g, any_spr_g, any_dsk_g, any_ref_g, any_cop_r;
  assign any_blt_g = |gnt_all[0 +: N_BLT];
  assign any_bpl_g = |gnt_all[O_BPL +: N_BPL];
  assign any_aud_g = |gnt_all[O_AUD +: N_AUD];
  assign any_spr_g = |gnt_all[O_SPR +: N_SPR];
  assign any_dsk_g = |gnt_all[O_DSK +: N_DSK];
  assign any_ref_g = |gnt_all[O_REF +: N_REF];
  assign any_cop_r = |req_all[O_COP +: N_COP];

  // consecutive throttled block-mover wins seen at the ports
  logic [2:0] blt_run;
  always_ff @(posedge clk) begin
    if (!rst_n || !(any_blt_g && cpu_req && !blt_pri)) blt_run <= '0;
    else if (blt_run != 3'(YIELD_EVERY-1))             blt_run <= blt_run + 1'b1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, gnt_all})); // R1
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_all & ~req_all) == '0) && (!cpu_gnt || cpu_req)); // R1
  AST_COP_OVER_AUD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cop_r && !any_blt_g && !any_bpl_g && !cpu_gnt) |-> !any_aud_g); // R2
  AST_EVEN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !hpos[0] && !any_blt_g) |-> cpu_gnt); // R3
  AST_ODD_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos[0] && any_cop_r) |-> !cpu_gnt); // R3
  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hpos < HW'(LINE_CYCLES)); // R5
  AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos == HW'(LINE_CYCLES-1)) |=> (hpos == '0)); // R5
  AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != HW'(LINE_CYCLES-1)) |=> (hpos == $past(hpos) + 1'b1)); // R5
  AST_AUD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_used == $bits(aud_used)'(AUD_BUDGET)) |-> !any_aud_g); // R6
  AST_DSK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_used == $bits(dsk_used)'(DSK_BUDGET)) |-> !any_dsk_g); // R6
  AST_REF_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_used == $bits(ref_used)'(REF_BUDGET)) |-> !any_ref_g); // R6
  AST_SPR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_used == $bits(spr_used)'(SPR_BUDGET)) |-> !any_spr_g); // R6
  AST_BPL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bpl_used == $bits(bpl_used)'(BPL_BUDGET) && !overscan_en) |-> !any_bpl_g); // R6
  AST_OVS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    (bpl_used == $bits(bpl_used)'(BPL_BUDGET) &&
     spr_used == $bits(spr_used)'(SPR_BUDGET)) |-> !any_bpl_g); // R9
  AST_BLT_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (blt_run == 3'(YIELD_EVERY-1) && cpu_req && !blt_pri) |-> !any_blt_g); // R7
  AST_BLT_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_all[0 +: N_BLT]) && blt_pri) |-> any_blt_g); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (hpos == '0 && aud_used == '0 && bpl_used == '0)); // R10

endmodule

bind dma_slot_arbiter dma_slot_arbiter_chk #(
  .N_BLT(N_BLT), .N_BPL(N_BPL), .N_COP(N_COP), .N_AUD(N_AUD), .N_SPR(N_SPR),
  .N_DSK(N_DSK), .N_REF(N_REF), .LINE_CYCLES(LINE_CYCLES),
  .BPL_BUDGET(BPL_BUDGET), .SPR_BUDGET(SPR_BUDGET), .AUD_BUDGET(AUD_BUDGET),
  .DSK_BUDGET(DSK_BUDGET), .REF_BUDGET(REF_BUDGET), .YIELD_EVERY(YIELD_EVERY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .blt_pri(blt_pri),
  .overscan_en(overscan_en), .req_all(all_req), .gnt_all(all_gnt),
  .cpu_gnt(cpu_gnt), .hpos(hpos), .bpl_used(bpl_used), .spr_used(spr_used),
  .aud_used(aud_used), .dsk_used(dsk_used), .ref_used(ref_used)
);

// File: tb/sim_dma_slot_arbiter.sv
`timescale 1ns/1ps
module sim_dma_slot_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, blt_pri = 1'b0, overscan_en = 1'b0;
  logic [24:0] req_all = '0;

  logic        cpu_gnt;
  logic [3:0]  blt_gnt;
  logic [5:0]  bpl_gnt;
  logic [0:0]  cop_gnt;
  logic [3:0]  aud_gnt;
  logic [7:0]  spr_gnt;
  logic [0:0]  dsk_gnt;
  logic [0:0]  ref_gnt;
  logic [7:0]  hpos;

  always #2.5 clk = ~clk;

  dma_slot_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .blt_pri(blt_pri),
    .overscan_en(overscan_en),
    .blt_req(req_all[3:0]), .bpl_req(req_all[9:4]), .cop_req(req_all[10:10]),
    .aud_req(req_all[14:11]), .spr_req(req_all[22:15]), .dsk_req(req_all[23:23]),
    .ref_req(req_all[24:24]),
    .cpu_gnt(cpu_gnt), .blt_gnt(blt_gnt), .bpl_gnt(bpl_gnt), .cop_gnt(cop_gnt),
    .aud_gnt(aud_gnt), .spr_gnt(spr_gnt), .dsk_gnt(dsk_gnt), .ref_gnt(ref_gnt),
    .hpos(hpos)
  );

  // ---------------- reference model ----------------
  localparam int LINE = 227;
  localparam int CPU  = 7;
  int GN  [7] = '{4, 6, 1, 4, 8, 1, 1};
  int GO  [7] = '{0, 4, 10, 11, 15, 23, 24};
  int CAP [7] = '{-1, 80, -1, 4, 16, 3, 4};
  int m_hp, m_y;
  int m_used [7];
  int m_rr   [7];

  int n_checks = 0, n_fail = 0;
  int cnt_grp [8];
  bit done = 0;
  string cur_tag = "R1";

  function automatic bit grp_has_req(int g);
    for (int k = 0; k < GN[g]; k++) if (req_all[GO[g]+k]) return 1;
    return 0;
  endfunction

  function automatic bit can_take(int g);
    if (g == CPU) return cpu_req;
    if (!grp_has_req(g)) return 0;
    if (g == 0) return !(!blt_pri && cpu_req && m_y >= 3);
    if (g == 1) return (m_used[1] < 80) || (overscan_en && m_used[4] < 16);
    if (CAP[g] < 0) return 1;
    return m_used[g] < CAP[g];
  endfunction

  function automatic int m_winner();
    int order[$];
    order = {};
    order.push_back(0);
    if (m_hp % 2 == 0) order.push_back(CPU);
    for (int g = 1; g < 7; g++) order.push_back(g);
    if (m_hp % 2 == 1) order.push_back(CPU);
    foreach (order[i]) if (can_take(order[i])) return order[i];
    return -1;
  endfunction

  function automatic int m_chan(int g);
    for (int k = 0; k < GN[g]; k++) begin
      int c = (m_rr[g] + k) % GN[g];
      if (req_all[GO[g]+c]) return GO[g] + c;
    end
    return -1;
  endfunction

  function automatic logic [25:0] m_expect();
    logic [25:0] e;
    int w;
    e = '0;
    w = m_winner();
    if (w == CPU) e[25] = 1'b1;
    else if (w >= 0) e[m_chan(w)] = 1'b1;
    return e;
  endfunction

  function automatic logic [25:0] dut_vec();
    return {cpu_gnt, ref_gnt, dsk_gnt, spr_gnt, aud_gnt, cop_gnt, bpl_gnt, blt_gnt};
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hp = 0; m_y = 0;
      for (int g = 0; g < 7; g++) begin m_used[g] = 0; m_rr[g] = 0; end
    end else begin
      int w, c;
      w = m_winner();
      if (w >= 0 && w != CPU) begin
        c = m_chan(w);
        m_rr[w] = (c - GO[w] + 1) % GN[w];
        if (w == 1) begin
          if (m_used[1] < 80) m_used[1]++; else m_used[4]++;
        end else if (w >= 3) m_used[w]++;
      end
      if (w == CPU || !cpu_req) m_y = 0;
      else if (w == 0 && m_y < 3) m_y++;
      if (m_hp == LINE-1) begin
        m_hp = 0;
        for (int g = 0; g < 7; g++) m_used[g] = 0;
      end else m_hp++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [25:0] e, d;
      e = m_expect();
      d = dut_vec();
      check(d == e, cur_tag, int'(d), int'(e));
      check(int'(hpos) == m_hp, "R5 hpos", int'(hpos), m_hp);
      for (int g = 0; g < 7; g++) if (|(d[GO[g] +: 8] & ((8'h1 << GN[g]) - 8'h1))) cnt_grp[g]++;
      if (d[25]) cnt_grp[CPU]++;
    end
  end

  task automatic clr_cnt();
    for (int g = 0; g < 8; g++) cnt_grp[g] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_all = '0; cpu_req = 0; blt_pri = 0; overscan_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clr_cnt();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: reset state
    cur_tag = "R10";
    do_reset();
    #2;
    check(hpos == 8'd0, "R10 hpos after reset", int'(hpos), 0);
    check(dut_vec() == '0, "R10 idle grants", int'(dut_vec()), 0);

    // R2: everything requesting for two lines
    cur_tag = "R2";
    @(negedge clk);
    req_all = '1; cpu_req = 1;
    repeat (2*LINE + 10) @(negedge clk);

    // R7: throttled block mover
    do_reset();
    cur_tag = "R7";
    req_all[3:0] = 4'hF; cpu_req = 1; blt_pri = 0;
    repeat (40) @(negedge clk);
    check(cnt_grp[CPU] == 10, "R7 cpu share", cnt_grp[CPU], 10);
    check(cnt_grp[0] == 30, "R7 blitter share", cnt_grp[0], 30);

    // R8: priority flag set
    do_reset();
    cur_tag = "R8";
    req_all[3:0] = 4'hF; cpu_req = 1; blt_pri = 1;
    repeat (40) @(negedge clk);
    check(cnt_grp[CPU] == 0, "R8 cpu locked out", cnt_grp[CPU], 0);

    // R4 rotation, R6 sound allowance, R5 wrap
    do_reset();
    cur_tag = "R4";
    req_all[14:11] = 4'hF;
    for (int k = 0; k < 5; k++) begin
      #2;
      if (k < 4) check(aud_gnt == 4'(1 << k), "R4 rotation", int'(aud_gnt), 1 << k);
      else       check(aud_gnt == 4'h0, "R6 sound exhausted", int'(aud_gnt), 0);
      @(negedge clk);
    end
    repeat (LINE - 5) @(negedge clk);
    check(hpos == 8'd0, "R5 wrap", int'(hpos), 0);
    check(cnt_grp[3] == 4, "R6 sound per line", cnt_grp[3], 4);
    clr_cnt();
    repeat (LINE) @(negedge clk);
    check(cnt_grp[3] == 4, "R5 refill next line", cnt_grp[3], 4);

    // R9 overscan pool, then R6 normal split
    do_reset();
    cur_tag = "R9";
    req_all[9:4] = 6'h3F; req_all[22:15] = 8'hFF; overscan_en = 1;
    repeat (LINE) @(negedge clk);
    check(cnt_grp[1] == 96, "R9 plane overscan", cnt_grp[1], 96);
    check(cnt_grp[4] == 0, "R9 objects starved", cnt_grp[4], 0);
    cur_tag = "R6";
    overscan_en = 0; clr_cnt();
    repeat (LINE) @(negedge clk);
    check(cnt_grp[1] == 80, "R6 plane cap", cnt_grp[1], 80);
    check(cnt_grp[4] == 16, "R6 object cap", cnt_grp[4], 16);

    // R6 floppy and refresh caps
    do_reset();
    req_all[23] = 1; req_all[24] = 1;
    repeat (LINE) @(negedge clk);
    check(cnt_grp[5] == 3, "R6 floppy cap", cnt_grp[5], 3);
    check(cnt_grp[6] == 4, "R6 refresh cap", cnt_grp[6], 4);

    // R11 unlimited display list
    do_reset();
    cur_tag = "R11";
    req_all[10] = 1;
    repeat (LINE) @(negedge clk);
    check(cnt_grp[2] == LINE, "R11 copper unlimited", cnt_grp[2], LINE);

    // R3 parity split
    do_reset();
    cur_tag = "R3";
    req_all[10] = 1; cpu_req = 1;
    repeat (20) @(negedge clk);
    check(cnt_grp[CPU] == 10, "R3 cpu even slots", cnt_grp[CPU], 10);
    check(cnt_grp[2] == 10, "R3 dma odd slots", cnt_grp[2], 10);
    req_all = '0; clr_cnt();
    repeat (20) @(negedge clk);
    check(cnt_grp[CPU] == 20, "R3 cpu takes free slots", cnt_grp[CPU], 20);

    // R1 mixed random traffic against the model
    do_reset();
    cur_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      req_all = 25'($urandom) & 25'($urandom);
      cpu_req = $urandom_range(0, 3) != 0;
      blt_pri = $urandom_range(0, 7) == 0;
      if (i % 300 == 0) overscan_en = $urandom_range(0, 1);
      @(negedge clk);
    end

    // R10 mid-line reset restores rotation start
    do_reset();
    cur_tag = "R10";
    req_all[14:11] = 4'hF;
    #2;
    check(aud_gnt == 4'h1, "R10 rotation restart", int'(aud_gnt), 1);
    check(hpos == 8'd0, "R10 hpos restart", int'(hpos), 0);
    @(negedge clk);
    #2;
    finish_run();
  end

endmodule